// File: doc/BRIEF.md
# External Data Memory Bus Cycle Stretcher

This block sequences data-memory accesses issued by an 8051-style core. Each request carries a 16-bit address, a direction bit, write data and a flag that marks 8-bit register-indirect addressing. A routing stage first decides where the access goes. Requests that fall inside the on-chip auxiliary RAM window are passed to a RAM port and complete in a single cycle. All other requests go to a multiplexed external bus, which is run by a small counter-driven state machine.

An external cycle has three phases. First the low address byte is placed on the shared data lines and the high byte on the upper address lines, with the latch-enable strobe raised. Next the latch enable drops while the address is still held. Finally an active-low read or write strobe is asserted. A configuration byte sets two lengths: the address phase (setup and hold) and the strobe pulse width. The latch enable toggles only during external cycles. A read captures the bus on the last strobe clock. Every access finishes with a one-cycle done pulse.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x23; ale is low, rd_n and wr_n are high, done is low and p0_oe is low.
- R2: During an external access ale is high for (A+1) clocks, where A is configuration bits [5:4]. During those clocks p0_out carries address bits [7:0], p2_out carries bits [15:8] and p0_oe is high.
- R3: After ale falls, the address stays on p0_out and p2_out for another (A+1) clocks before any strobe is asserted.
- R4: One external access asserts exactly one of rd_n (read) or wr_n (write). It stays low for (W+1) consecutive clocks, where W is configuration bits [2:0], and ale is low throughout.
- R5: While wr_n is low, p0_out carries the write data and p0_oe is high. While rd_n is low, p0_oe is low.
- R6: A read returns the value p0_in had on the last clock of the read strobe. done is high for exactly one clock: the clock right after the strobe ends, which is 2(A+1)+(W+1)+1 clocks after the request clock.
- R7: With aux_dis low and a full-width address below 0x0400, the access goes to the RAM port (ram_req, ram_we, ram_addr = address[9:0], ram_wdata). done follows in the next clock, returning ram_rdata for reads. There is no ale or strobe activity, and p0_out and p2_out keep their values.
- R8: With aux_dis high, every access goes to the external bus, including addresses below 0x0400. ram_req stays low.
- R9: With aux_dis low and req_short high, address bits [15:8] are ignored and the access goes to RAM location address[7:0]. With aux_dis high, a short access drives the full address externally.
- R10: A configuration write while an access is in progress is ignored, and the configuration byte keeps its old value. A write made while idle takes effect from the next access.
- R11: Addresses from 0x0400 upward go to the external bus even when aux_dis is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_wdata | input | 8 | Configuration byte: [5:4] address stretch, [2:0] strobe stretch |
| cfg_q | output | 8 | Current configuration byte |
| aux_dis | input | 1 | High sends every access to the external bus |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 8-bit register-indirect addressing |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ram_req | output | 1 | Auxiliary RAM access strobe |
| ram_we | output | 1 | Auxiliary RAM write enable |
| ram_addr | output | 10 | Auxiliary RAM address |
| ram_wdata | output | 8 | Auxiliary RAM write data |
| ram_rdata | input | 8 | Auxiliary RAM read data, combinational |
| ale | output | 1 | Address latch enable |
| p0_out | output | 8 | Multiplexed low address / data out |
| p0_oe | output | 1 | Drive enable for p0_out |
| p0_in | input | 8 | Multiplexed data in |
| p2_out | output | 8 | High address byte |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume the requester raises req_valid only after the done pulse of the previous access. Under that assumption, the upper address and the configuration byte seen during a busy period come from a single accepted request. They also assume the RAM answers in the same cycle. The bench therefore waits for done before issuing the next request, and it changes aux_dis only between accesses. The one exception is a deliberate configuration write during a bus cycle, which exercises the case where such a write must be ignored. Phase lengths are measured by counting ale, hold and strobe clocks at the ports. p0_in is given a different value on every strobe clock, so a read sampled on the wrong clock is detected.

// File: rtl/xms_pkg.sv
package xms_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_HOLD   = 2'd2,
      ST_STROBE = 2'd3
   } xms_state_e;

endpackage

// File: rtl/xms_cfg_reg.sv
module xms_cfg_reg #(
   parameter int          CFG_W     = 8,
   parameter logic [CFG_W-1:0] RESET_VAL = 8'h23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic             busy,
   output logic [CFG_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else if (we && !busy)
         q <= wdata;
   end

endmodule

// File: rtl/xms_route.sv
module xms_route #(
   parameter int ADDR_W    = 16,
   parameter int SHORT_W   = 8,
   parameter int AUX_DEPTH = 1024,
   localparam int AUX_AW   = (AUX_DEPTH > 1) ? $clog2(AUX_DEPTH) : 1
) (
   input  logic              aux_dis,
   input  logic              short_mode,
   input  logic [ADDR_W-1:0] addr,
   output logic              to_aux,
   output logic [AUX_AW-1:0] aux_addr
);

   initial begin
      assert (SHORT_W <= ADDR_W) else $error("xms_route: SHORT_W exceeds ADDR_W");
      assert (AUX_DEPTH <= (1 << ADDR_W)) else $error("xms_route: window too large");
   end

   generate
      if (AUX_DEPTH > 0) begin : g_aux
         logic [ADDR_W-1:0] eff;
         always_comb begin
            if (short_mode)
               eff = {{(ADDR_W-SHORT_W){1'b0}}, addr[SHORT_W-1:0]};
            else
               eff = addr;
            to_aux   = !aux_dis && (eff < ADDR_W'(AUX_DEPTH));
            aux_addr = eff[AUX_AW-1:0];
         end
      end else begin : g_no_aux
         assign to_aux   = 1'b0;
         assign aux_addr = '0;
      end
   endgenerate

endmodule

// File: rtl/xms_seq.sv
module xms_seq
   import xms_pkg::*;
#(
   parameter int  ADDR_W = 16,
   parameter int  DATA_W = 8,
   parameter int  AS_W   = 2,
   parameter int  PW_W   = 3,
   localparam int HI_W   = ADDR_W - DATA_W,
   localparam int CNT_W  = (AS_W > PW_W) ? AS_W : PW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AS_W-1:0]   as_f,
   input  logic [PW_W-1:0]   pw_f,
   input  logic [DATA_W-1:0] p0_in,
   output logic              busy,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] p0_out,
   output logic              p0_oe,
   output logic [HI_W-1:0]   p2_out,
   output logic              ext_done,
   output logic [DATA_W-1:0] ext_rdata
);

   initial begin
      assert (ADDR_W > DATA_W) else $error("xms_seq: address must be wider than data");
      assert (AS_W > 0 && PW_W > 0) else $error("xms_seq: stretch fields must be non-empty");
   end

   xms_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wd_q;
   logic              wr_q;
   logic              last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         addr_q    <= '0;
         wd_q      <= '0;
         wr_q      <= 1'b0;
         ext_done  <= 1'b0;
         ext_rdata <= '0;
      end else begin
         ext_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_SETUP;
                  cnt    <= CNT_W'(as_f);
                  addr_q <= addr;
                  wd_q   <= wdata;
                  wr_q   <= wr;
               end
            end
            ST_SETUP: begin
               if (last) begin
                  state <= ST_HOLD;
                  cnt   <= CNT_W'(as_f);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               if (last) begin
                  state <= ST_STROBE;
                  cnt   <= CNT_W'(pw_f);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (last) begin
                  state    <= ST_IDLE;
                  ext_done <= 1'b1;
                  if (!wr_q)
                     ext_rdata <= p0_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   always_comb begin
      busy   = (state != ST_IDLE);
      ale    = (state == ST_SETUP);
      rd_n   = !((state == ST_STROBE) && !wr_q);
      wr_n   = !((state == ST_STROBE) && wr_q);
      p0_oe  = (state == ST_SETUP) || (state == ST_HOLD) ||
               ((state == ST_STROBE) && wr_q);
      p0_out = ((state == ST_STROBE) && wr_q) ? wd_q : addr_q[DATA_W-1:0];
      p2_out = addr_q[ADDR_W-1:DATA_W];
   end

   // R4: never both strobes
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   // R4: latch enable quiet while a strobe is low
   a_r4_no_ale_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !ale);
   // R6: completion lasts one clock
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ext_done |=> !ext_done);
   // R6: completion directly follows a strobe
   a_r6_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ext_done |-> ($past(!rd_n) || $past(!wr_n)));
   // R3: high address held through a bus cycle
   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(p2_out));

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl #(
   parameter int  ADDR_W    = 16,
   parameter int  DATA_W    = 8,
   parameter int  AUX_DEPTH = 1024,
   parameter int  SHORT_W   = 8,
   parameter int  AS_W      = 2,
   parameter int  AS_LSB    = 4,
   parameter int  PW_W      = 3,
   parameter int  PW_LSB    = 0,
   parameter int  CFG_W     = 8,
   parameter logic [CFG_W-1:0] CFG_RESET = 8'h23,
   localparam int AUX_AW    = (AUX_DEPTH > 1) ? $clog2(AUX_DEPTH) : 1,
   localparam int HI_W      = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_q,
   input  logic              aux_dis,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_short,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              ram_req,
   output logic              ram_we,
   output logic [AUX_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ale,
   output logic [DATA_W-1:0] p0_out,
   output logic              p0_oe,
   input  logic [DATA_W-1:0] p0_in,
   output logic [HI_W-1:0]   p2_out,
   output logic              rd_n,
   output logic              wr_n
);

   initial begin
      assert (AS_LSB + AS_W <= CFG_W) else $error("address field outside config byte");
      assert (PW_LSB + PW_W <= CFG_W) else $error("pulse field outside config byte");
   end

   logic              busy;
   logic              to_aux;
   logic              take;
   logic              ext_done;
   logic [DATA_W-1:0] ext_rdata;
   logic              aux_done_q;
   logic [DATA_W-1:0] aux_rdata_q;

   xms_cfg_reg #(.CFG_W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .busy(busy), .q(cfg_q)
   );

   xms_route #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .AUX_DEPTH(AUX_DEPTH)) u_route (
      .aux_dis(aux_dis), .short_mode(req_short), .addr(req_addr),
      .to_aux(to_aux), .aux_addr(ram_addr)
   );

   assign take = req_valid && !busy;

   xms_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AS_W(AS_W), .PW_W(PW_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(take && !to_aux), .wr(req_write),
      .addr(req_addr), .wdata(req_wdata),
      .as_f(cfg_q[AS_LSB +: AS_W]), .pw_f(cfg_q[PW_LSB +: PW_W]),
      .p0_in(p0_in), .busy(busy), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
      .ext_done(ext_done), .ext_rdata(ext_rdata)
   );

   assign ram_req   = take && to_aux;
   assign ram_we    = req_write;
   assign ram_wdata = req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_done_q  <= 1'b0;
         aux_rdata_q <= '0;
      end else begin
         aux_done_q <= ram_req;
         if (ram_req && !req_write)
            aux_rdata_q <= ram_rdata;
      end
   end

   assign done  = ext_done || aux_done_q;
   assign rdata = aux_done_q ? aux_rdata_q : ext_rdata;

   // R8: disabled window never reaches the RAM port
   a_r8_no_ram_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      aux_dis |-> !ram_req);
   // R7: a RAM access leaves the external bus idle
   a_r7_ram_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req |=> (!ale && rd_n && wr_n && done));
   // R9: short addressing stays inside the low page of the window
   a_r9_short_page: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req && req_short) |-> (ram_addr[AUX_AW-1:SHORT_W] == '0));
   // R10: configuration frozen during a bus cycle
   a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

// File: tb/tb_xmem_stretch_ctrl.sv
module tb_xmem_stretch_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_wdata;
   logic [7:0]  cfg_q;
   logic        aux_dis;
   logic        req_valid, req_write, req_short;
   logic [15:0] req_addr;
   logic [7:0]  req_wdata;
   logic        done;
   logic [7:0]  rdata;
   logic        ram_req, ram_we;
   logic [9:0]  ram_addr;
   logic [7:0]  ram_wdata, ram_rdata;
   logic        ale, p0_oe, rd_n, wr_n;
   logic [7:0]  p0_out, p0_in, p2_out;

   int checks = 0;
   int bad    = 0;
   int cyc    = 0;

   logic [7:0] mem    [1024];
   logic [7:0] shadow [1024];

   always #5 clk = ~clk;

   xmem_stretch_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .aux_dis(aux_dis), .req_valid(req_valid), .req_write(req_write),
      .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rdata(rdata), .ram_req(ram_req), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .ale(ale), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   assign ram_rdata = mem[ram_addr];
   always @(posedge clk) if (ram_req && ram_we) mem[ram_addr] <= ram_wdata;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         bad = bad + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<100000", cyc);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   localparam int NV = 10;
   localparam logic [7:0]  V_CFG [NV] = '{8'h23, 8'h00, 8'h37, 8'h12, 8'h23,
                                          8'h23, 8'h23, 8'h23, 8'h05, 8'h21};
   localparam logic        V_DIS [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 1};
   localparam logic        V_WR  [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0, 1};
   localparam logic        V_SH  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
   localparam logic [15:0] V_ADR [NV] = '{16'h1234, 16'h8001, 16'hFFFF, 16'h0400,
                                          16'h03FF, 16'h0010, 16'h0010, 16'h0010,
                                          16'hAB20, 16'hAB20};
   localparam logic [7:0]  V_WD  [NV] = '{8'h00, 8'h5C, 8'h00, 8'hE1, 8'h00,
                                          8'h77, 8'h00, 8'h00, 8'h00, 8'h9D};

   // run one access; midcfg>=0 issues a config write on the 2nd busy clock
   task automatic access(input logic [7:0] cfg, input logic dis, input logic wr,
                         input logic sh, input logic [15:0] adr, input logic [7:0] wd,
                         input int midcfg);
      int s_len, p_len, n, ale_n, hold_n, strb_n;
      bit ext, seen_ale;
      logic [9:0] ea;
      logic [7:0] p0_before, p2_before;
      s_len = int'(cfg[5:4]) + 1;
      p_len = int'(cfg[2:0]) + 1;
      ext   = dis || (!sh && adr >= 16'h0400);
      ea    = sh ? {2'b00, adr[7:0]} : adr[9:0];
      n = 0; ale_n = 0; hold_n = 0; strb_n = 0; seen_ale = 0;
      @(negedge clk);
      aux_dis = dis;
      p0_before = p0_out; p2_before = p2_out;
      req_valid = 1'b1; req_write = wr; req_short = sh; req_addr = adr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 64; k++) begin
         n = n + 1;
         if (ale) begin
            ale_n = ale_n + 1; seen_ale = 1;
            if (p0_out != adr[7:0] || p2_out != adr[15:8] || !p0_oe)
               chk(0, "R2 address during ale", {p2_out, p0_out}, adr);
         end else if (!rd_n || !wr_n) begin
            strb_n = strb_n + 1;
            p0_in = 8'hA0 + 8'(strb_n - 1);
            if (wr && (wr_n || !rd_n)) chk(0, "R4 strobe type (write)", {rd_n, wr_n}, 2'b10);
            if (!wr && (rd_n || !wr_n)) chk(0, "R4 strobe type (read)", {rd_n, wr_n}, 2'b01);
            if (wr && (p0_out != wd || !p0_oe)) chk(0, "R5 write data", p0_out, wd);
            if (!wr && p0_oe) chk(0, "R5 bus released on read", p0_oe, 0);
         end else if (seen_ale && strb_n == 0) begin
            hold_n = hold_n + 1;
            if (p0_out != adr[7:0] || p2_out != adr[15:8])
               chk(0, "R3 address held", {p2_out, p0_out}, adr);
         end
         if (midcfg >= 0) begin
            cfg_we = (n == 2); cfg_wdata = 8'(midcfg);
         end
         if (done) break;
         @(negedge clk);
      end
      cfg_we = 1'b0;
      if (ext) begin
         chk(ale_n == s_len, "R2 ale clocks", ale_n, s_len);
         chk(hold_n == s_len, "R3 hold clocks", hold_n, s_len);
         chk(strb_n == p_len, "R4 strobe clocks", strb_n, p_len);
         chk(n == 2 * s_len + p_len + 1, "R6 done timing", n, 2 * s_len + p_len + 1);
         if (!wr) chk(rdata == 8'hA0 + 8'(p_len - 1), "R6 read sample", rdata, 8'hA0 + 8'(p_len - 1));
         if (dis && adr < 16'h0400) chk(1, "R8 low address external", 0, 0);
      end else begin
         chk(n == 1 && ale_n == 0 && strb_n == 0, "R7 aux one cycle, quiet bus",
             n * 256 + ale_n + strb_n, 256);
         chk(p0_out == p0_before && p2_out == p2_before, "R7 port regs unchanged",
             {p2_out, p0_out}, {p2_before, p0_before});
         if (wr) shadow[ea] = wd;
         else chk(rdata == shadow[ea], sh ? "R9 short read" : "R7 aux read", rdata, shadow[ea]);
      end
      @(negedge clk);
      chk(!done, "R6 done one clock", done, 0);
   endtask

   task automatic set_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(cfg_q == v, "R10 idle config write", cfg_q, v);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i] = 8'(i) ^ 8'h5A;
         shadow[i] = 8'(i) ^ 8'h5A;
      end
      rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; aux_dis = 0;
      req_valid = 0; req_write = 0; req_short = 0; req_addr = 0; req_wdata = 0;
      p0_in = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_q == 8'h23, "R1 config reset", cfg_q, 8'h23);
      chk(!ale && rd_n && wr_n && !done && !p0_oe, "R1 bus idle after reset",
          {ale, rd_n, wr_n, done, p0_oe}, 5'b01100);

      for (int v = 0; v < NV; v++) begin
         if (cfg_q != V_CFG[v]) set_cfg(V_CFG[v]);
         access(V_CFG[v], V_DIS[v], V_WR[v], V_SH[v], V_ADR[v], V_WD[v], -1);
      end

      // R11 boundary: 0x0400 went external above; 0x03FF aux; recheck ale stays low idle
      repeat (3) begin
         @(negedge clk);
         chk(!ale && rd_n && wr_n, "R11 bus idle between accesses", {ale, rd_n, wr_n}, 3'b011);
      end

      // R10 write during a bus cycle ignored, old timing used
      set_cfg(8'h11);
      access(8'h11, 1'b0, 1'b0, 1'b0, 16'h5000, 8'h00, 8'h37);
      chk(cfg_q == 8'h11, "R10 busy config write ignored", cfg_q, 8'h11);
      set_cfg(8'h34);
      access(8'h34, 1'b0, 1'b1, 1'b0, 16'hC0DE, 8'h3C, -1);

      // R9 short access with aux enabled reads back the R7 write at 0x10
      access(8'h34, 1'b0, 1'b0, 1'b1, 16'hFF10, 8'h00, -1);

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule